// File: doc/BRIEF.md
# INTEST Single-Step Core Clock Gater

This block supplies the clock and the advance permission for on-chip core logic. In normal operation the free-running system clock goes straight to the core and the core is never held. While the internal-test instruction is active, the core may only move forward while the test controller sits in its idle run state. Shifting of the boundary-scan register happens in other controller states, so the core stands still during shifts.

Two single-step variants are chosen with a mode input. In the test-clock mode the core clock is the test clock, gated so that it pulses only while the idle-state flag is true. In the pulse mode the system clock keeps running to the core. A hold-release output rises for exactly one system-clock cycle each time the controller enters the idle state, so the core performs one step per entry. A saturating counter reports how many steps have been issued since the internal-test instruction was selected.

Both clock paths use a latch-based gate whose enable can only change while its clock is low. A pulse reaching the core is therefore always a whole pulse of its source clock.

Top module: `intest_step_clkgate`

## Requirements
- R1: While rst_n is low at a system-clock edge, step_cnt becomes 0. With intest low, step_en reads 1.
- R2: With intest low, core_clk has one rising edge for every rising edge of sys_clk, tck has no effect on core_clk, and step_en is 1.
- R3: With intest high and mode_sel = 0 (test-clock mode), core_clk rises once for each rising edge of tck whose preceding low phase saw rti_idle high, and never otherwise. Edges of sys_clk do not reach core_clk, and step_en is 1.
- R4: With intest high and mode_sel = 1 (pulse mode), core_clk follows every rising edge of sys_clk. After each rising transition of rti_idle, step_en is high for exactly one sys_clk cycle, starting on the second sys_clk rising edge after the transition.
- R5: In pulse mode, step_en stays 0 for as long as rti_idle stays constant, whether high or low. Shifting with rti_idle low therefore never advances the core.
- R6: Each step_en pulse in pulse mode raises step_cnt by one on the following sys_clk edge. step_cnt saturates at 2^CNT_W-1.
- R7: step_cnt is 0 on the sys_clk edge after any cycle in which intest is low. When a step pulse and the leave of intest fall together, the clear wins. A later pulse-mode step then counts from 1 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Synchronous active-low reset, sys_clk domain |
| tck | input | 1 | Test clock |
| rti_idle | input | 1 | High while the test controller is in its idle run state (tck domain) |
| intest | input | 1 | Internal-test instruction is current; assumed quasi-static |
| mode_sel | input | 1 | 0 = test-clock gating, 1 = one-cycle step pulse on idle entry |
| core_clk | output | 1 | Clock delivered to the core logic |
| step_en | output | 1 | Core advance permission (hold released when 1) |
| step_cnt | output | CNT_W | Saturating number of steps issued since intest was selected |

## Verification
Two of the block's functions can fall in the same system-clock cycle: the step pulse and the clear that happens when the instruction is left. The bench raises rti_idle and drops intest one cycle later, while the rising transition is still inside the synchronizer. It then requires step_cnt to be 0 and step_en to be 1. After intest returns with rti_idle still high, no step may appear. The next real entry must count 1 again. A second clash is the increment at saturation, which is judged against a bench model that stops at the maximum.

// File: rtl/intest_step_pkg.sv
// Package: shared types for the single-step core clock gater.
// Assumes nothing; holds only the mode encoding.
package intest_step_pkg;

    // Single-step variant chosen by mode_sel.
    typedef enum logic {
        STEP_MODE_TCK   = 1'b0,
        STEP_MODE_PULSE = 1'b1
    } step_mode_e;

endpackage

// File: rtl/clk_gate_cell.sv
// Glitch-free clock gate: the enable is captured by a latch that is
// transparent only while the clock is low, so the gated output can only
// start or stop on whole clock pulses.
// Assumes en settles during the low phase of clk.
module clk_gate_cell (
    input  logic clk,
    input  logic en,
    output logic gclk
);

    logic en_lat;

    // Hold the enable steady across the high phase of clk.
    always_latch begin
        if (!clk) begin
            en_lat = en;
        end
    end

    // Pass clk only while the latched enable is set.
    assign gclk = clk & en_lat;

endmodule

// File: rtl/rti_entry_sync.sv
// Brings the idle-state flag into the system-clock domain through a
// SYNC_STAGES-flop synchronizer, then flags each rising transition for
// exactly one cycle.
// Assumes the flag stays high or low for at least SYNC_STAGES+1 system cycles.
module rti_entry_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise_pulse
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   last_q;

    // Shift the asynchronous flag through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], async_in};
        end
    end

    // Remember the previous synchronized value for the edge detector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= 1'b0;
        end else begin
            last_q <= sync_q[SYNC_STAGES-1];
        end
    end

    assign rise_pulse = sync_q[SYNC_STAGES-1] & ~last_q;

endmodule

// File: rtl/step_counter.sv
// Saturating counter of issued steps. It is cleared whenever clr is high,
// and the clear takes priority over an increment in the same cycle.
// Assumes a synchronous active-low reset in the counting clock domain.
module step_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    // Clear, increment or hold the step count.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            count <= '0;
        end else if (inc && count != CNT_MAX) begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/intest_step_clkgate.sv
// Top: core clock and step permission for single-step internal test.
// Normal operation passes sys_clk and keeps step_en high. With intest set,
// mode_sel picks test-clock gating during the idle state or a one-cycle
// step_en pulse per idle-state entry with sys_clk running freely.
// Assumes intest and mode_sel change only while the core clock may stop,
// and rti_idle changes on tck rising edges.
module intest_step_clkgate
    import intest_step_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             sys_clk,
    input  logic             rst_n,
    input  logic             tck,
    input  logic             rti_idle,
    input  logic             intest,
    input  logic             mode_sel,
    output logic             core_clk,
    output logic             step_en,
    output logic [CNT_W-1:0] step_cnt
);

    localparam int N_SRC   = 2;
    localparam int SRC_SYS = 0;
    localparam int SRC_TCK = 1;

    step_mode_e       mode;
    logic [N_SRC-1:0] src_clk;
    logic [N_SRC-1:0] src_en;
    logic [N_SRC-1:0] src_gclk;
    logic             rti_rise;
    logic             step_pulse;

    assign mode = step_mode_e'(mode_sel);

    // Choose which clock source may reach the core.
    always_comb begin
        src_clk          = '0;
        src_en           = '0;
        src_clk[SRC_SYS] = sys_clk;
        src_clk[SRC_TCK] = tck;
        src_en[SRC_SYS]  = !intest || (mode == STEP_MODE_PULSE);
        src_en[SRC_TCK]  = intest && (mode == STEP_MODE_TCK) && rti_idle;
    end

    // One glitch-free gate per clock source.
    for (genvar g = 0; g < N_SRC; g++) begin : g_gate
        clk_gate_cell u_gate (
            .clk  (src_clk[g]),
            .en   (src_en[g]),
            .gclk (src_gclk[g])
        );
    end

    assign core_clk = |src_gclk;

    rti_entry_sync #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_sync (
        .clk        (sys_clk),
        .rst_n      (rst_n),
        .async_in   (rti_idle),
        .rise_pulse (rti_rise)
    );

    // A step is granted only in pulse mode while the test is current.
    always_comb begin
        step_pulse = rti_rise && intest && (mode == STEP_MODE_PULSE);
        step_en    = !intest || (mode == STEP_MODE_TCK) || step_pulse;
    end

    step_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk   (sys_clk),
        .rst_n (rst_n),
        .clr   (!intest),
        .inc   (step_pulse),
        .count (step_cnt)
    );

endmodule

// File: rtl/intest_step_clkgate_chk.sv
// Checker: port-level properties of the single-step gater, bound to the top.
// Assumes sampling on sys_clk with the same synchronous reset.
module intest_step_clkgate_chk #(
    parameter int CNT_W = 8
) (
    input logic             sys_clk,
    input logic             rst_n,
    input logic             intest,
    input logic             mode_sel,
    input logic             step_en,
    input logic [CNT_W-1:0] step_cnt
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    // R2: outside internal test the core is never held.
    a_r2_run_free: assert property (@(posedge sys_clk) disable iff (!rst_n)
        !intest |-> step_en);

    // R4: a pulse-mode step lasts a single cycle.
    a_r4_one_cycle: assert property (@(posedge sys_clk) disable iff (!rst_n)
        (intest && mode_sel && step_en) |=> (!intest || !mode_sel || !step_en));

    // R6: each step adds one below the maximum.
    a_r6_count_up: assert property (@(posedge sys_clk) disable iff (!rst_n)
        (intest && mode_sel && step_en && step_cnt != CNT_MAX)
        |=> (step_cnt == $past(step_cnt) + 1'b1));

    // R6: the count holds at its maximum.
    a_r6_saturate: assert property (@(posedge sys_clk) disable iff (!rst_n)
        (intest && step_cnt == CNT_MAX) |=> (step_cnt == CNT_MAX));

    // R7: leaving internal test clears the count.
    a_r7_clear: assert property (@(posedge sys_clk) disable iff (!rst_n)
        !intest |=> (step_cnt == '0));

endmodule

bind intest_step_clkgate intest_step_clkgate_chk #(
    .CNT_W (CNT_W)
) u_chk (
    .sys_clk  (sys_clk),
    .rst_n    (rst_n),
    .intest   (intest),
    .mode_sel (mode_sel),
    .step_en  (step_en),
    .step_cnt (step_cnt)
);

// File: tb/intest_step_clkgate_tb_top.sv
// Bench: scoreboard of expected step counts filled by the driver and
// drained by a monitor on every observed step pulse, plus window checks
// of core clock edges per mode.
module intest_step_clkgate_tb_top;

    localparam int CNT_W = 3;
    localparam int CMAX  = (1 << CNT_W) - 1;

    logic             sys_clk  = 1'b0;
    logic             rst_n    = 1'b0;
    logic             tck      = 1'b0;
    logic             rti_idle = 1'b0;
    logic             intest   = 1'b0;
    logic             mode_sel = 1'b0;
    logic             core_clk;
    logic             step_en;
    logic [CNT_W-1:0] step_cnt;

    int n_checks = 0;
    int n_fail   = 0;
    int core_edges = 0;
    int exp_cnt  = 0;
    int exp_q[$];
    bit pend     = 1'b0;
    bit done     = 1'b0;

    intest_step_clkgate #(.CNT_W(CNT_W)) dut_i (
        .sys_clk  (sys_clk),
        .rst_n    (rst_n),
        .tck      (tck),
        .rti_idle (rti_idle),
        .intest   (intest),
        .mode_sel (mode_sel),
        .core_clk (core_clk),
        .step_en  (step_en),
        .step_cnt (step_cnt)
    );

    // 125 MHz system clock.
    always #4 sys_clk = ~sys_clk;

    // Count every rising edge that reaches the core.
    always @(posedge core_clk) core_edges++;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    // Monitor: each pulse-mode step is matched against the scoreboard one cycle later.
    always @(negedge sys_clk) begin
        if (pend) begin
            pend = 1'b0;
            if (exp_q.size() == 0) begin
                check(1'b0, "R5 unexpected step", 1, 0);
            end else begin
                int e;
                e = exp_q.pop_front();
                check(int'(step_cnt) == e, "R6 step count", int'(step_cnt), e);
            end
        end
        if (rst_n && intest && mode_sel && step_en) pend = 1'b1;
    end

    // One tck cycle with rti_idle set during the low phase.
    task automatic tck_cycle(input bit rti_v);
        rti_idle = rti_v;
        #20 tck = 1'b1;
        #20 tck = 1'b0;
    endtask

    // Driver: one idle-state entry in pulse mode, expectation pushed first.
    task automatic rti_entry();
        exp_cnt = (exp_cnt < CMAX) ? exp_cnt + 1 : CMAX;
        exp_q.push_back(exp_cnt);
        rti_idle = 1'b1;
        repeat (6) @(negedge sys_clk);
        rti_idle = 1'b0;
        repeat (6) @(negedge sys_clk);
    endtask

    // Watchdog.
    initial begin
        #(200000 * 8);
        check(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        int base;
        int edges_seen;
        // R1: reset state.
        repeat (5) @(negedge sys_clk);
        check(step_cnt == '0, "R1 reset count", int'(step_cnt), 0);
        check(step_en == 1'b1, "R1 reset step_en", int'(step_en), 1);
        rst_n = 1'b1;
        repeat (2) @(negedge sys_clk);

        // R2: pass-through with tck toggling alongside.
        base = core_edges;
        fork
            repeat (20) @(negedge sys_clk);
            repeat (4) tck_cycle(1'b1);
        join
        edges_seen = core_edges - base;
        check(edges_seen == 20, "R2 sys edges pass", edges_seen, 20);
        check(step_en == 1'b1, "R2 step_en high", int'(step_en), 1);
        rti_idle = 1'b0;

        // R3: test-clock mode, only idle-state tck pulses reach the core.
        @(negedge sys_clk);
        intest = 1'b1;
        mode_sel = 1'b0;
        repeat (3) @(negedge sys_clk);
        base = core_edges;
        tck_cycle(1'b1); tck_cycle(1'b0); tck_cycle(1'b0);
        tck_cycle(1'b1); tck_cycle(1'b1); tck_cycle(1'b0);
        edges_seen = core_edges - base;
        check(edges_seen == 3, "R3 gated tck pulses", edges_seen, 3);
        base = core_edges;
        repeat (4) tck_cycle(1'b0);
        edges_seen = core_edges - base;
        check(edges_seen == 0, "R3 no pulse while shifting", edges_seen, 0);
        check(step_en == 1'b1, "R3 step_en high", int'(step_en), 1);
        check(step_cnt == '0, "R3 count stays zero", int'(step_cnt), 0);

        // R4: pulse mode, system clock runs freely.
        @(negedge sys_clk);
        mode_sel = 1'b1;
        repeat (3) @(negedge sys_clk);
        base = core_edges;
        repeat (10) @(negedge sys_clk);
        edges_seen = core_edges - base;
        check(edges_seen == 10, "R4 free-running core clock", edges_seen, 10);
        check(step_en == 1'b0, "R5 held while idle flag low", int'(step_en), 0);

        // R4 timing: pulse on the second edge after the transition.
        exp_cnt = 1;
        exp_q.push_back(1);
        rti_idle = 1'b1;
        @(negedge sys_clk);
        check(step_en == 1'b0, "R4 no step after one edge", int'(step_en), 0);
        @(negedge sys_clk);
        check(step_en == 1'b1, "R4 step after two edges", int'(step_en), 1);
        @(negedge sys_clk);
        check(step_en == 1'b0, "R4 step one cycle", int'(step_en), 0);
        // R5: staying in idle gives no further steps.
        repeat (12) @(negedge sys_clk);
        check(step_en == 1'b0, "R5 held while idle flag high", int'(step_en), 0);
        rti_idle = 1'b0;
        repeat (12) @(negedge sys_clk);

        // R6: more entries, through saturation.
        repeat (CMAX + 1) rti_entry();
        check(int'(step_cnt) == CMAX, "R6 saturated", int'(step_cnt), CMAX);

        // R7: step in flight collides with leaving the instruction.
        rti_idle = 1'b1;
        @(negedge sys_clk);
        intest = 1'b0;
        exp_cnt = 0;
        repeat (3) @(negedge sys_clk);
        check(step_cnt == '0, "R7 clear wins", int'(step_cnt), 0);
        check(step_en == 1'b1, "R7 run after leave", int'(step_en), 1);
        intest = 1'b1;
        repeat (6) @(negedge sys_clk);
        check(step_cnt == '0, "R7 no step on re-select", int'(step_cnt), 0);
        rti_idle = 1'b0;
        repeat (6) @(negedge sys_clk);
        rti_entry();
        check(step_cnt == 1, "R7 counts from one again", int'(step_cnt), 1);

        repeat (4) @(negedge sys_clk);
        check(exp_q.size() == 0, "R4 all steps seen", exp_q.size(), 0);
        finish_run();
    end

endmodule